// File: doc/BRIEF.md
# Serial Run-of-Ones Terminator Detector

This block watches a single serial bit that is presented once per clock cycle and tracks how many consecutive 1s have been seen, with the count saturating at three. When a 0 arrives and closes a run of at least three 1s, the block raises a one-cycle pulse in that same cycle. Any 0 sends the tracker back to its idle state, so the next run is counted from zero.

The pulse is a Mealy output. It is a combinational function of the stored run state and the bit on the input during the current cycle, so a consumer registers it on the same clock edge that consumes the bit. The two-bit run state is also brought out so that the surrounding logic can see how far a run has progressed.

Top module: `run_terminator_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the state after that edge is idle. The state encodings on `state_o` are idle=00, one-seen=01, two-seen=10 and saturated=11.
- R2: With `bit_i`=1, the state advances idle to one-seen, one-seen to two-seen, and two-seen to saturated at the next rising edge.
- R3: With `bit_i`=1, the saturated state remains saturated, however long the run is.
- R4: With `bit_i`=0, every state returns to idle at the next rising edge.
- R5: `hit_o` is 1 in the same cycle whenever the state is saturated and `bit_i` is 0, without waiting for a clock edge.
- R6: `hit_o` is 0 for every other combination of state and `bit_i`. This includes runs of only one or two 1s that end in a 0.
- R7: After a terminating 0, detection restarts from idle. A later pulse requires three fresh 1s followed by a 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit, one per cycle |
| hit_o | output | 1 | Pulse on the 0 that terminates a run of at least three 1s |
| state_o | output | 2 | Current run state (idle=00, one-seen=01, two-seen=10, saturated=11) |

## Verification
`hit_o` is due in the same cycle as the bit that produces it. `state_o` moves one rising edge after the bit that moves it. The bench changes `bit_i` and `rst` on the falling edge and samples 2 ns later, before the next rising edge. At that point each sample pairs the new bit with the state left by the previous edge. Each driven bit therefore yields exactly one scoreboard entry, holding that cycle's expected pulse and the expected state that produced it. Test patterns cover short runs, a run of exactly three, a long saturated run, back-to-back runs, and a reset in the middle of a run.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_SAT  = 2'b11
  } run_state_t;
endpackage

// File: rtl/rtd_next_state.sv
module rtd_next_state
  import rtd_pkg::*;
(
  input  run_state_t cur_i,
  input  logic       bit_i,
  output run_state_t nxt_o
);
  always_comb begin
    if (!bit_i) begin
      nxt_o = ST_IDLE;
    end else begin
      unique case (cur_i)
        ST_IDLE: nxt_o = ST_ONE;
        ST_ONE:  nxt_o = ST_TWO;
        ST_TWO:  nxt_o = ST_SAT;
        default: nxt_o = ST_SAT;
      endcase
    end
  end
endmodule

// File: rtl/rtd_state_reg.sv
module rtd_state_reg
  import rtd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  run_state_t nxt_i,
  output run_state_t cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= ST_IDLE;
    else     cur_o <= nxt_i;
  end
endmodule

// File: rtl/rtd_hit_decode.sv
module rtd_hit_decode
  import rtd_pkg::*;
(
  input  run_state_t cur_i,
  input  logic       bit_i,
  output logic       hit_o
);
  always_comb hit_o = (cur_i == ST_SAT) && !bit_i;
endmodule

// File: rtl/run_terminator_detect.sv
module run_terminator_detect
  import rtd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_i,
  output logic               hit_o,
  output logic [STATE_W-1:0] state_o
);
  run_state_t cur_q;
  run_state_t nxt_c;

  rtd_next_state i_next (.cur_i(cur_q), .bit_i(bit_i), .nxt_o(nxt_c));
  rtd_state_reg  i_reg  (.clk(clk), .rst(rst), .nxt_i(nxt_c), .cur_o(cur_q));
  rtd_hit_decode i_hit  (.cur_i(cur_q), .bit_i(bit_i), .hit_o(hit_o));

  assign state_o = cur_q;

  // R1: synchronous reset lands in idle
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> cur_q == ST_IDLE);

  // R2: a 1 advances the run count
  a_r2_advance_one: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_IDLE && bit_i) |=> cur_q == ST_ONE);
  a_r2_advance_two: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_ONE && bit_i) |=> cur_q == ST_TWO);
  a_r2_advance_sat: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_TWO && bit_i) |=> cur_q == ST_SAT);

  // R3: saturated state holds on further 1s
  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_SAT && bit_i) |=> cur_q == ST_SAT);

  // R4: any 0 clears to idle
  a_r4_zero_clears: assert property (@(posedge clk) disable iff (rst)
    !bit_i |=> cur_q == ST_IDLE);

  // R5/R6: a pulse only comes from the saturated state on a 0
  a_r6_hit_needs_sat: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (cur_q == ST_SAT && !bit_i));

  // R7: after a pulse, detection restarts from idle and cannot pulse again at once
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> (cur_q == ST_IDLE && !hit_o));
endmodule

// File: tb/test_run_terminator_detect.sv
module test_run_terminator_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_i = 1'b0;
  logic       hit_o;
  logic [1:0] state_o;

  run_terminator_detect i_run_terminator_detect (
    .clk(clk), .rst(rst), .bit_i(bit_i), .hit_o(hit_o), .state_o(state_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic       exp_hit;
    logic [1:0] exp_state;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  int         checks = 0;
  int         errors = 0;
  logic [1:0] model_st = 2'b00;

  // driver: applies one bit on the falling edge and queues what must be seen
  task automatic drive(input logic r, input logic b, input string tag);
    item_t it;
    @(negedge clk);
    rst   = r;
    bit_i = b;
    it.exp_hit   = (model_st == 2'b11) && !b;
    it.exp_state = model_st;
    it.tag       = tag;
    sb_q.push_back(it);
    if (r || !b)              model_st = 2'b00;
    else if (model_st != 2'b11) model_st = model_st + 2'b01;
  endtask

  // monitor: compares 2 ns after each falling edge, before the rising edge
  always @(negedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (state_o !== it.exp_state) begin
        errors++;
        $display("FAIL %s state actual=%b expected=%b", it.tag, state_o, it.exp_state);
      end
      checks++;
      if (hit_o !== it.exp_hit) begin
        errors++;
        $display("FAIL %s hit actual=%b expected=%b", it.tag, hit_o, it.exp_hit);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    model_st = 2'b00;
    drive(1'b1, 1'b0, "R1");
    drive(1'b0, 1'b0, "R1");
    // short runs ending in 0: no pulse
    drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b0, "R6");
    drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b0, "R6");
    drive(1'b0, 1'b0, "R4");
    // exactly three ones then zero
    drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b1, "R2");
    drive(1'b0, 1'b0, "R5");
    drive(1'b0, 1'b0, "R4");
    // long saturated run
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b1, "R3");
    drive(1'b0, 1'b0, "R5");
    // restart: two ones then zero must not pulse, then a fresh full run must
    drive(1'b0, 1'b1, "R7");
    drive(1'b0, 1'b1, "R7");
    drive(1'b0, 1'b0, "R7");
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, "R7");
    drive(1'b0, 1'b0, "R7");
    drive(1'b0, 1'b1, "R6");
    // reset in the middle of a saturated run
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, "R3");
    drive(1'b1, 1'b1, "R1");
    drive(1'b0, 1'b0, "R1");
    drive(1'b0, 1'b0, "R4");
    // alternating pattern never pulses
    for (int i = 0; i < 6; i++) drive(1'b0, i[0], "R6");
    drive(1'b0, 1'b0, "R4");
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule